// File: doc/BRIEF.md
# Section Translation Walker with Translation Cache

This block turns a 32-bit virtual address into a physical address using a single-level table of 1 MB section descriptors kept in memory. The table has 4096 word-sized entries, one for each 1 MB slice of the 4 GB space. The table is indexed by the top twelve virtual address bits. A requester offers an address with a valid/ready handshake. The block then does one of two things. It answers from a four-entry, fully associative cache of recent section translations, or it fetches the one descriptor that governs the address through a simple read port. In both cases it returns a single response: the physical address, a section fault, or an unsupported-type code.

The two lowest descriptor bits select its type. A section entry supplies the upper twelve physical address bits, and the low twenty bits pass through from the virtual address. Entries marked invalid raise a section fault. An entry that would point to a finer second-level table is refused with its own status. Each half of the address space has a walk-disable control. When the control for the half being looked up is set and the cache misses, a fault is returned without touching memory. An invalidate-all input empties the cache at once.

Top module: `sect_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_req is 0 and the translation cache holds no entry.
- R2: On a cache miss with the walk allowed, exactly one descriptor read is issued. mem_req is high for the single cycle after acceptance. mem_addr is {table base bits [31:14] as sampled at acceptance, vaddr[31:20], 2'b00}.
- R3: A descriptor with bits [1:0] = 2'b10 gives rsp_status 2'b00 and rsp_paddr = {descriptor[31:20], vaddr[19:0]}. For example, a descriptor of 0x3EF00002 at index 0 maps 0x00000000..0x000FFFFF onto 0x3EF00000..0x3EFFFFFF.
- R4: A descriptor with bits [1:0] = 2'b00 or 2'b11 gives rsp_status 2'b01 (section fault) with rsp_paddr 0.
- R5: A descriptor with bits [1:0] = 2'b01 gives rsp_status 2'b10 (unsupported second-level pointer) with rsp_paddr 0.
- R6: walk_dis[vaddr[31]] is sampled at acceptance. If that bit is set and the cache misses, the response is a section fault (2'b01) in the cycle after acceptance, and no read is made.
- R7: A cache hit is answered with status 2'b00 in the cycle after acceptance. No memory read is made, walk_dis has no effect, and req_ready stays high.
- R8: The cache holds 4 entries, filled in round-robin order starting with entry 0. Only section descriptors are cached, so a faulting or unsupported index is fetched again on every request.
- R9: inv_all empties the cache by the next cycle. A lookup in the same cycle misses, and a fill that falls in the same cycle is dropped without advancing the replacement order.
- R10: req_ready is low from the cycle after a walk is accepted until the response cycle. Each accepted request gets exactly one rsp_valid pulse. For a walk, that pulse comes in the cycle after mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 18 | Table base address bits [31:14] |
| walk_dis | input | 2 | Walk disable; bit 1 for vaddr[31]=1, bit 0 otherwise |
| inv_all | input | 1 | Empty the translation cache |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 00 ok, 01 section fault, 10 unsupported |
| rsp_paddr | output | 32 | Physical address (0 unless ok) |
| mem_req | output | 1 | Descriptor read strobe |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Descriptor word |

## Verification
Cache invalidation can fall in the same cycle as a request lookup, and it can also fall in the same cycle as the fill that ends a walk. The bench provokes the first by raising inv_all together with req_valid on an address known to be cached. It provokes the second by having its memory model raise inv_all in the cycle it returns the descriptor. In both cases the behavioural reference decides the outcome. The first must produce a fresh walk rather than a hit. After the second, a repeat of the same address must walk again, and later evictions must follow the replacement order unchanged.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int VA_W  = 32;
  localparam int IDX_W = 12;
  localparam int OFF_W = VA_W - IDX_W;
  localparam int BASE_W = VA_W - IDX_W - 2;

  typedef enum logic [1:0] {
    XS_OK    = 2'b00,
    XS_FAULT = 2'b01,
    XS_UNSUP = 2'b10
  } xstat_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_WAIT  = 2'b10
  } xstate_e;
endpackage

// File: rtl/xlt_decode.sv
module xlt_decode
  import xlt_pkg::*;
(
  input  logic [VA_W-1:0]  desc,
  output xstat_e           stat,
  output logic [IDX_W-1:0] pbase
);
  logic unused_mid;
  assign unused_mid = ^desc[OFF_W-1:2];
  assign pbase = desc[VA_W-1:OFF_W];

  always_comb begin
    unique case (desc[1:0])
      2'b10:   stat = XS_OK;
      2'b01:   stat = XS_UNSUP;
      default: stat = XS_FAULT;
    endcase
  end
endmodule

// File: rtl/xlt_cache.sv
module xlt_cache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 12,
  parameter int DATA_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              inv_all
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, vld_d, hit_vec;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q, rr_d;
  logic               wr_ok;

  assign wr_ok = fill_en & ~inv_all;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  assign lk_hit = (|hit_vec) & ~inv_all;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) lk_data = lk_data | dat_q[i];
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (wr_ok) begin
      vld_d[rr_q] = 1'b1;
      rr_d = (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + PTR_W'(1);
    end
    if (inv_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      tag_q[rr_q] <= fill_tag;
      dat_q[rr_q] <= fill_data;
    end
  end

  // No tag may sit in two entries (fills only follow a miss)
  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_inv_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0));
endmodule

// File: rtl/sect_xlate.sv
module sect_xlate
  import xlt_pkg::*;
#(
  parameter int CACHE_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [BASE_W-1:0] tbl_base,
  input  logic [1:0]        walk_dis,
  input  logic              inv_all,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              mem_req,
  output logic [VA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [VA_W-1:0]   mem_rdata
);
  xstate_e           st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic [BASE_W-1:0] base_q;
  logic              rsp_v_d;
  xstat_e            stat_q, stat_d;
  logic [VA_W-1:0]   pa_q, pa_d;
  logic              accept, region_off, lk_hit, fill_en;
  logic [IDX_W-1:0]  lk_pbase, dec_pbase;
  xstat_e            dec_stat;

  assign accept     = (st_q == ST_IDLE) && req_valid;
  assign region_off = walk_dis[req_vaddr[VA_W-1]];

  xlt_cache #(.ENTRIES(CACHE_ENTRIES), .TAG_W(IDX_W), .DATA_W(IDX_W)) u_cache (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit    (lk_hit),
    .lk_data   (lk_pbase),
    .fill_en   (fill_en),
    .fill_tag  (va_q[VA_W-1:OFF_W]),
    .fill_data (dec_pbase),
    .inv_all   (inv_all)
  );

  xlt_decode u_dec (
    .desc  (mem_rdata),
    .stat  (dec_stat),
    .pbase (dec_pbase)
  );

  always_comb begin
    st_d    = st_q;
    rsp_v_d = 1'b0;
    stat_d  = stat_q;
    pa_d    = pa_q;
    fill_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (lk_hit) begin
            rsp_v_d = 1'b1;
            stat_d  = XS_OK;
            pa_d    = {lk_pbase, req_vaddr[OFF_W-1:0]};
          end else if (region_off) begin
            rsp_v_d = 1'b1;
            stat_d  = XS_FAULT;
            pa_d    = '0;
          end else begin
            st_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: st_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          rsp_v_d = 1'b1;
          stat_d  = dec_stat;
          pa_d    = (dec_stat == XS_OK) ? {dec_pbase, va_q[OFF_W-1:0]} : '0;
          fill_en = (dec_stat == XS_OK);
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= rsp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      va_q   <= req_vaddr;
      base_q <= tbl_base;
    end
    if (rsp_v_d) begin
      stat_q <= stat_d;
      pa_q   <= pa_d;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign mem_req    = (st_q == ST_FETCH);
  assign mem_addr   = {base_q, va_q[VA_W-1:OFF_W], 2'b00};
  assign rsp_status = stat_q;
  assign rsp_paddr  = pa_q;

  assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == XS_OK) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != XS_OK) |-> (rsp_paddr == '0));

  assert_miss_fetches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lk_hit && !region_off) |=> (mem_req && !rsp_valid));

  assert_disabled_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lk_hit && region_off) |=> (rsp_valid && rsp_status == XS_FAULT && !mem_req));

  assert_no_early_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (!rsp_valid && !req_ready));
endmodule

// File: tb/sect_xlate_test.sv
`timescale 1ns/1ps
module sect_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [17:0] tbl_base = 18'h00C01;
  logic [1:0]  walk_dis = 2'b00;
  logic        inv_task = 1'b0, inv_mem = 1'b0;
  logic        inv_all;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  assign inv_all = inv_task | inv_mem;

  sect_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .walk_dis(walk_dis),
    .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;

  // Descriptor contents of the bench's table (computed, not stored)
  function automatic logic [31:0] gen_desc(input logic [11:0] idx);
    logic [1:0] t;
    if (idx == 12'd0) return 32'h3EF0_0002;
    case (idx[2:0])
      3'd1: t = 2'b01;
      3'd3: t = 2'b00;
      3'd5: t = 2'b11;
      default: t = 2'b10;
    endcase
    return {idx ^ 12'h5A3, 18'h25A5A, t};
  endfunction

  // Memory model
  int lat = 1, cnt = 0;
  bit inv_at_rv = 0;
  logic [31:0] pend_addr;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    inv_mem    = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        inv_mem    = inv_at_rv;
        if (pend_addr[31:14] == tbl_base && pend_addr[1:0] == 2'b00)
          mem_rdata = gen_desc(pend_addr[13:2]);
        else
          mem_rdata = 32'h0;
      end
    end
    if (mem_req) begin
      pend_addr = mem_addr;
      cnt = lat;
    end
  end

  // Behavioural reference model
  int m_st = 0, rr = 0;
  bit c_v [4];
  logic [11:0] c_tag [4], c_pb [4];
  logic [31:0] cur_va;
  logic [17:0] cur_base;
  bit exp_ready = 1, exp_rv = 0, exp_mreq = 0;
  logic [1:0] exp_stat;
  logic [31:0] exp_pa, exp_maddr;
  string tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; rr = 0;
      for (int i = 0; i < 4; i++) c_v[i] = 0;
      exp_ready = 1; exp_rv = 0; exp_mreq = 0; tag = "R1";
    end else begin
      exp_rv = 0;
      case (m_st)
        0: if (req_valid) begin
          int hit;
          hit = -1;
          cur_va = req_vaddr; cur_base = tbl_base;
          if (!inv_all)
            for (int i = 0; i < 4; i++)
              if (c_v[i] && c_tag[i] == req_vaddr[31:20]) hit = i;
          if (hit >= 0) begin
            exp_rv = 1; exp_stat = 2'b00; exp_pa = {c_pb[hit], req_vaddr[19:0]};
            tag = "R7 cache hit";
          end else if (walk_dis[req_vaddr[31]]) begin
            exp_rv = 1; exp_stat = 2'b01; exp_pa = 0; tag = "R6 walk disabled";
          end else begin
            m_st = 1; tag = inv_all ? "R9 lookup during invalidate" : "R2 descriptor fetch";
          end
        end
        1: m_st = 2;
        2: if (mem_rvalid) begin
          logic [31:0] d;
          d = gen_desc(cur_va[31:20]);
          exp_rv = 1; m_st = 0;
          if (d[1:0] == 2'b10) begin
            exp_stat = 2'b00; exp_pa = {d[31:20], cur_va[19:0]}; tag = "R3 section";
            if (!inv_all) begin
              c_v[rr] = 1; c_tag[rr] = cur_va[31:20]; c_pb[rr] = d[31:20];
              rr = (rr + 1) % 4;
            end else tag = "R9 fill dropped";
          end else if (d[1:0] == 2'b01) begin
            exp_stat = 2'b10; exp_pa = 0; tag = "R5 unsupported";
          end else begin
            exp_stat = 2'b01; exp_pa = 0; tag = "R4 invalid descriptor";
          end
        end
        default: m_st = 0;
      endcase
      if (inv_all) for (int i = 0; i < 4; i++) c_v[i] = 0;
      exp_ready = (m_st == 0);
      exp_mreq  = (m_st == 1);
      exp_maddr = {cur_base, cur_va[31:20], 2'b00};
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      vectors++;
      bad = (req_ready !== exp_ready) || (rsp_valid !== exp_rv) || (mem_req !== exp_mreq)
         || (exp_mreq && mem_addr !== exp_maddr)
         || (exp_rv && (rsp_status !== exp_stat || rsp_paddr !== exp_pa));
      if (bad) begin
        fails++;
        $display("FAIL %s R10 t=%0t: ready=%0b/%0b rv=%0b/%0b st=%0h/%0h pa=%h/%h mreq=%0b/%0b maddr=%h/%h (actual/expected)",
          tag, $time, req_ready, exp_ready, rsp_valid, exp_rv, rsp_status, exp_stat,
          rsp_paddr, exp_pa, mem_req, exp_mreq, mem_addr, exp_maddr);
      end
    end
  end

  task automatic send(input logic [31:0] va, input bit inv);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; inv_task = inv;
    @(negedge clk);
    req_valid = 1'b0; inv_task = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R10 watchdog expired: cycles=%0d expected<100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lf;
    #1;
    vectors++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_req !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: ready=%0b rv=%0b mreq=%0b expected 1 0 0", req_ready, rsp_valid, mem_req);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 empty cache: a first request to index 0 must walk
    send(32'h0001_2345, 0);               // R3 example mapping
    send(32'h000F_FFFF, 0);               // R7 hit -> 0x3EFFFFFF
    send(32'h0010_0000, 0);               // R5 idx1 unsupported
    send(32'h0030_0004, 0);               // R4 type 00
    send(32'h0050_0008, 0);               // R4 type 11
    send(32'h0030_0004, 0);               // R8 faults not cached
    // R8 round-robin eviction
    send(32'h0020_0010, 0);
    send(32'h0040_0020, 0);
    send(32'h0060_0030, 0);
    send(32'h0070_0040, 0);               // evicts idx0
    send(32'h0000_0100, 0);               // walks again
    send(32'h0070_0044, 0);               // hit
    // R6 walk disable
    walk_dis = 2'b01;
    send(32'h0080_0000, 0);               // miss, lower half -> fault
    send(32'h0070_0048, 0);               // hit ignores disable (R7)
    send(32'h8020_0000, 0);               // upper half walks
    walk_dis = 2'b10;
    send(32'h8040_0000, 0);               // fault
    walk_dis = 2'b00;
    // R9 collisions
    send(32'h0070_0050, 1);               // inv with lookup -> walk
    send(32'h0070_0054, 0);               // now hit
    lat = 3; inv_at_rv = 1;
    send(32'h00A0_0000, 0);               // fill dropped
    inv_at_rv = 0;
    send(32'h00A0_0004, 0);               // walks again
    send(32'h00A0_0008, 0);               // hit
    // R2 new table base, latencies
    tbl_base = 18'h2B7F0;
    lf = 32'hACE1_2345;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lat = 1 + (k % 3);
      walk_dis = (k % 17 == 0) ? 2'b11 : 2'b00;
      send({1'b0, 4'h0, lf[26:24], lf[23:0]}, (k % 23 == 0));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule